// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register face of a node in a doorbell scheme shared by several partitions. Software sees a 256-byte window of 32-bit registers. It holds an interrupt mask, an interrupt status, a read-only local node ID and a write-only ring register. A write to the ring register names a destination peer and a vector in one word. A small table holds how many vectors each peer has, and the block checks the ring against it. A ring that passes both checks becomes a one-cycle notify pulse toward the fabric. A ring that fails either check is dropped without any trace.

Event strobes arriving for the local node take one of two paths. In level mode they set the status register, and the interrupt line is high while any status bit is also enabled in the mask. In message mode the line stays low. Each event becomes a per-vector message request, or a pending bit while that vector is masked. Pending bits are released once the vector is unmasked.

Top module: `doorbell_irq_regs`

## Requirements
- R1: `irq_o` is high exactly when `msg_mode_i` is low and (status AND mask) is nonzero. It follows the registers in the cycle after they change.
- R2: A read at offset 0x04 returns the status in `rdata_o` one cycle later and clears all status bits in the same access.
- R3: A write at offset 0x00 replaces the whole mask, and a write at offset 0x04 replaces the whole status.
- R4: Offset 0x00 reads the mask and offset 0x08 reads `local_id_i` zero-extended. Reads of 0x0C and of any other offset return 0, and writes to offsets other than 0x00, 0x04 and 0x0C do nothing. `rdata_o` is updated only by a read and holds otherwise.
- R5: An access with `addr_i[1:0]` nonzero is not decoded. A write changes nothing, and a read returns 0 without clearing status.
- R6: A write at 0x0C takes the destination peer from bits 31:16 and the vector from bits 7:0; bits 15:8 are ignored. A ring that passes both checks drives `ring_o` high for one cycle, in the cycle after the write, with `ring_peer_o` and `ring_vec_o`.
- R7: A ring is dropped when the destination is not below `num_peers_i` or not below MAX_PEERS.
- R8: A ring is dropped when its vector is not below the vector count held in the table for that destination.
- R9: `tbl_we_i` loads `tbl_nvec_i` into the table entry `tbl_idx_i`. A ring in the same cycle is checked against the old entry. Reset sets every entry to 0.
- R10: While `msg_mode_i` and `msg_en_i` are both high, an event on an unmasked vector V raises `msg_req_o` for one cycle, in the next cycle, with `msg_vec_o` = V. In message mode `irq_o` is always low.
- R11: While `msg_mode_i` and `msg_en_i` are both high, an event on a vector masked in `vec_mask_i` sets bit V of `pend_o` and raises no request.
- R12: In a cycle with both modes high and no event, the lowest pending vector that is unmasked issues a request and has its pending bit cleared. A live event takes the cycle first.
- R13: An event while `msg_mode_i` or `msg_en_i` is low writes the value 1 into the status register. This overrides a bus write or a read-clear of status in the same cycle.
- R14: Reset clears the mask, the status, `rdata_o`, all pending bits and both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| local_id_i | input | 16 | This node's peer ID |
| num_peers_i | input | 16 | Current peer count |
| tbl_we_i | input | 1 | Vector-count table write |
| tbl_idx_i | input | PIDX_W | Table entry to write |
| tbl_nvec_i | input | 8 | Vector count for that peer |
| ring_o | output | 1 | Notify pulse |
| ring_peer_o | output | 16 | Notify destination |
| ring_vec_o | output | 8 | Notify vector |
| evt_i | input | 1 | Local event strobe |
| evt_vec_i | input | VEC_W | Local event vector |
| msg_mode_i | input | 1 | Message-signalled delivery selected |
| msg_en_i | input | 1 | Message delivery enabled |
| vec_mask_i | input | NUM_VEC | Per-vector message mask |
| msg_req_o | output | 1 | Message request pulse |
| msg_vec_o | output | VEC_W | Requested vector |
| pend_o | output | NUM_VEC | Pending vectors |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong mask or status value shows on `irq_o` in the cycle after it is written. It also shows on `rdata_o` after the next read, and a read-clear that fails leaves `irq_o` high. A corrupted table entry or a wrong range compare shows up as a missing or extra `ring_o` pulse in the cycle after the write, so the bench rings at the edges of both limits. Lost or stuck pending state is visible at once on `pend_o`. The release order shows on `msg_vec_o` as each vector is unmasked.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_W   = 16;
  localparam int unsigned DBV_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_LID  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RING = 8'h0C;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [ADDR_W-1:0] off;
  } acc_t;
endpackage

// File: rtl/dbr_regfile.sv
module dbr_regfile
  import dbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_t              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ID_W-1:0]   lid_i,
  input  logic              evt_set_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mask_q, stat_q, rdata_q, rd_mux;

  always_comb begin
    unique case (acc_i.off)
      OFF_MASK: rd_mux = mask_q;
      OFF_STAT: rd_mux = stat_q;
      OFF_LID:  rd_mux = DATA_W'(lid_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (acc_i.wr && acc_i.off == OFF_MASK) mask_q <= wdata_i;
      // event write of 1 wins over bus write and read-clear
      if (evt_set_i)                              stat_q <= DATA_W'(1);
      else if (acc_i.wr && acc_i.off == OFF_STAT) stat_q <= wdata_i;
      else if (acc_i.rd && acc_i.off == OFF_STAT) stat_q <= '0;
      if (acc_i.rd) rdata_q <= rd_mux;
    end
  end

  assign mask_o  = mask_q;
  assign stat_o  = stat_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/dbr_ring.sv
module dbr_ring
  import dbr_pkg::*;
#(
  parameter int unsigned MAX_PEERS = 8,
  parameter int unsigned PIDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_t              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ID_W-1:0]   num_peers_i,
  input  logic              tbl_we_i,
  input  logic [PIDX_W-1:0] tbl_idx_i,
  input  logic [DBV_W-1:0]  tbl_nvec_i,
  output logic              ring_o,
  output logic [ID_W-1:0]   ring_peer_o,
  output logic [DBV_W-1:0]  ring_vec_o
);
  logic [DBV_W-1:0] lim_q [MAX_PEERS];

  for (genvar g = 0; g < MAX_PEERS; g++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         lim_q[g] <= '0;
      else if (tbl_we_i && tbl_idx_i == PIDX_W'(g))        lim_q[g] <= tbl_nvec_i;
    end
  end

  logic [ID_W-1:0]  dest;
  logic [DBV_W-1:0] vec, lim;
  logic             in_tbl, hit;

  assign dest   = wdata_i[31:16];
  assign vec    = wdata_i[7:0];
  assign in_tbl = 32'(dest) < MAX_PEERS;
  assign lim    = in_tbl ? lim_q[dest[PIDX_W-1:0]] : '0;
  assign hit    = acc_i.wr && acc_i.off == OFF_RING && dest < num_peers_i
                  && in_tbl && vec < lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_o      <= 1'b0;
      ring_peer_o <= '0;
      ring_vec_o  <= '0;
    end else begin
      ring_o <= hit;
      if (hit) begin
        ring_peer_o <= dest;
        ring_vec_o  <= vec;
      end
    end
  end
endmodule

// File: rtl/dbr_event.sv
module dbr_event #(
  parameter int unsigned NUM_VEC = 8,
  parameter int unsigned VEC_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic [VEC_W-1:0]   evt_vec_i,
  input  logic               msg_mode_i,
  input  logic               msg_en_i,
  input  logic [NUM_VEC-1:0] vec_mask_i,
  output logic               stat_set_o,
  output logic               msg_req_o,
  output logic [VEC_W-1:0]   msg_vec_o,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] pend_q, pend_nxt, ready;
  logic [VEC_W-1:0]   sel;
  logic               any, deliver, evt_masked, fire;

  assign deliver    = msg_mode_i && msg_en_i;
  assign stat_set_o = evt_i && !deliver;
  assign evt_masked = vec_mask_i[evt_vec_i];
  assign ready      = pend_q & ~vec_mask_i;
  assign any        = |ready;

  always_comb begin
    sel = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (ready[i]) sel = VEC_W'(i);
    end
  end

  always_comb begin
    pend_nxt = pend_q;
    if (deliver) begin
      if (evt_i && evt_masked) pend_nxt[evt_vec_i] = 1'b1;
      else if (!evt_i && any)  pend_nxt[sel] = 1'b0;
    end
  end

  assign fire = deliver && (evt_i ? !evt_masked : any);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      msg_req_o <= 1'b0;
      msg_vec_o <= '0;
    end else begin
      pend_q    <= pend_nxt;
      msg_req_o <= fire;
      if (fire) msg_vec_o <= evt_i ? evt_vec_i : sel;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/doorbell_irq_regs.sv
module doorbell_irq_regs
  import dbr_pkg::*;
#(
  parameter  int unsigned MAX_PEERS = 8,
  parameter  int unsigned NUM_VEC   = 8,
  localparam int unsigned PIDX_W    = $clog2(MAX_PEERS),
  localparam int unsigned VEC_W     = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [15:0]        local_id_i,
  input  logic [15:0]        num_peers_i,
  input  logic               tbl_we_i,
  input  logic [PIDX_W-1:0]  tbl_idx_i,
  input  logic [7:0]         tbl_nvec_i,
  output logic               ring_o,
  output logic [15:0]        ring_peer_o,
  output logic [7:0]         ring_vec_o,
  input  logic               evt_i,
  input  logic [VEC_W-1:0]   evt_vec_i,
  input  logic               msg_mode_i,
  input  logic               msg_en_i,
  input  logic [NUM_VEC-1:0] vec_mask_i,
  output logic               msg_req_o,
  output logic [VEC_W-1:0]   msg_vec_o,
  output logic [NUM_VEC-1:0] pend_o,
  output logic               irq_o
);
  acc_t              acc;
  logic [DATA_W-1:0] mask_w, stat_w;
  logic              stat_set;

  // full-offset compare rejects unaligned addresses
  assign acc.rd  = req_i && !we_i;
  assign acc.wr  = req_i && we_i;
  assign acc.off = addr_i;

  dbr_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .wdata_i   (wdata_i),
    .lid_i     (local_id_i),
    .evt_set_i (stat_set),
    .mask_o    (mask_w),
    .stat_o    (stat_w),
    .rdata_o   (rdata_o)
  );

  dbr_ring #(.MAX_PEERS(MAX_PEERS), .PIDX_W(PIDX_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .wdata_i     (wdata_i),
    .num_peers_i (num_peers_i),
    .tbl_we_i    (tbl_we_i),
    .tbl_idx_i   (tbl_idx_i),
    .tbl_nvec_i  (tbl_nvec_i),
    .ring_o      (ring_o),
    .ring_peer_o (ring_peer_o),
    .ring_vec_o  (ring_vec_o)
  );

  dbr_event #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .evt_vec_i  (evt_vec_i),
    .msg_mode_i (msg_mode_i),
    .msg_en_i   (msg_en_i),
    .vec_mask_i (vec_mask_i),
    .stat_set_o (stat_set),
    .msg_req_o  (msg_req_o),
    .msg_vec_o  (msg_vec_o),
    .pend_o     (pend_o)
  );

  assign irq_o = !msg_mode_i && |(mask_w & stat_w);
endmodule

// File: rtl/dbr_chk.sv
module dbr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic        evt_i,
  input logic        msg_mode_i,
  input logic        msg_en_i,
  input logic [15:0] num_peers_i,
  input logic        irq_o,
  input logic [31:0] rdata_o,
  input logic        ring_o,
  input logic [15:0] ring_peer_o,
  input logic        msg_req_o,
  input logic [31:0] mask_w,
  input logic [31:0] stat_w
);
  logic rd_stat;
  assign rd_stat = req_i && !we_i && addr_i == 8'h04;

  p_rdclr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !evt_i) |=> stat_w == 32'h0);

  p_rdval_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> rdata_o == $past(stat_w));

  p_unaligned_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[1:0] != 2'b00) |=> $stable(mask_w));

  p_unaligned_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] != 2'b00) |=> rdata_o == 32'h0);

  p_ring_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_o |-> ring_peer_o < $past(num_peers_i));

  p_msg_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o |-> $past(msg_mode_i && msg_en_i));

  p_line_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_mode_i |-> !irq_o);
endmodule

bind doorbell_irq_regs dbr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .evt_i       (evt_i),
  .msg_mode_i  (msg_mode_i),
  .msg_en_i    (msg_en_i),
  .num_peers_i (num_peers_i),
  .irq_o       (irq_o),
  .rdata_o     (rdata_o),
  .ring_o      (ring_o),
  .ring_peer_o (ring_peer_o),
  .msg_req_o   (msg_req_o),
  .mask_w      (mask_w),
  .stat_w      (stat_w)
);

// File: tb/doorbell_irq_regs_test.sv
module doorbell_irq_regs_test;
  localparam int NP = 8;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] lid = 16'h00A5, npeers = 16'd0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [7:0]  tbl_nvec = '0;
  logic        ring;
  logic [15:0] ring_peer;
  logic [7:0]  ring_vec;
  logic        evt = 1'b0;
  logic [2:0]  evt_vec = '0;
  logic        mmode = 1'b0, men = 1'b0;
  logic [7:0]  vmask = '0;
  logic        msg_req;
  logic [2:0]  msg_vec;
  logic [7:0]  pend;
  logic        irq;

  int tot = 0, bad = 0;
  bit done = 0;
  string tag = "R14";

  always #2 clk = ~clk;

  doorbell_irq_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .local_id_i(lid), .num_peers_i(npeers),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_nvec_i(tbl_nvec),
    .ring_o(ring), .ring_peer_o(ring_peer), .ring_vec_o(ring_vec),
    .evt_i(evt), .evt_vec_i(evt_vec), .msg_mode_i(mmode), .msg_en_i(men),
    .vec_mask_i(vmask), .msg_req_o(msg_req), .msg_vec_o(msg_vec),
    .pend_o(pend), .irq_o(irq)
  );

  // reference model state
  logic [31:0] m_mask, m_stat, m_rdata;
  logic        m_ring, m_msg;
  logic [15:0] m_rpeer;
  logic [7:0]  m_rvec;
  logic [2:0]  m_mvec;
  logic [7:0]  m_pend;
  int          m_tbl [NP];

  task automatic model_reset();
    m_mask = 0; m_stat = 0; m_rdata = 0; m_ring = 0; m_msg = 0;
    m_rpeer = 0; m_rvec = 0; m_mvec = 0; m_pend = 0;
    for (int i = 0; i < NP; i++) m_tbl[i] = 0;
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("irq_o", 32'(irq), 32'(!mmode && ((m_mask & m_stat) != 0)));
    chk("rdata_o", rdata, m_rdata);
    chk("ring_o", 32'(ring), 32'(m_ring));
    if (m_ring) begin
      chk("ring_peer_o", 32'(ring_peer), 32'(m_rpeer));
      chk("ring_vec_o", 32'(ring_vec), 32'(m_rvec));
    end
    chk("msg_req_o", 32'(msg_req), 32'(m_msg));
    if (m_msg) chk("msg_vec_o", 32'(msg_vec), 32'(m_mvec));
    chk("pend_o", 32'(pend), 32'(m_pend));
  endtask

  task automatic tick();
    logic [31:0] n_mask = m_mask, n_stat = m_stat, n_rdata = m_rdata;
    logic        n_ring = 0, n_msg = 0;
    logic [15:0] n_rpeer = m_rpeer;
    logic [7:0]  n_rvec = m_rvec, n_pend = m_pend;
    logic [2:0]  n_mvec = m_mvec;
    int          dest = int'(wdata[31:16]);
    int          vec = int'(wdata[7:0]);
    int          found = -1;
    if (req && !we) begin
      case (addr)
        8'h00: n_rdata = m_mask;
        8'h04: begin n_rdata = m_stat; n_stat = 0; end
        8'h08: n_rdata = {16'h0, lid};
        default: n_rdata = 0;
      endcase
    end
    if (req && we) begin
      if (addr == 8'h00) n_mask = wdata;
      if (addr == 8'h04) n_stat = wdata;
      if (addr == 8'h0C && dest < int'(npeers) && dest < NP && vec < m_tbl[dest]) begin
        n_ring = 1; n_rpeer = wdata[31:16]; n_rvec = wdata[7:0];
      end
    end
    if (evt && !(mmode && men)) n_stat = 1;
    if (mmode && men) begin
      if (evt) begin
        if (vmask[evt_vec]) n_pend[evt_vec] = 1;
        else begin n_msg = 1; n_mvec = evt_vec; end
      end else begin
        for (int i = NV - 1; i >= 0; i--) if (m_pend[i] && !vmask[i]) found = i;
        if (found >= 0) begin n_msg = 1; n_mvec = 3'(found); n_pend[found] = 0; end
      end
    end
    @(posedge clk);
    #1;
    if (tbl_we) m_tbl[tbl_idx] = int'(tbl_nvec);
    m_mask = n_mask; m_stat = n_stat; m_rdata = n_rdata; m_ring = n_ring;
    m_rpeer = n_rpeer; m_rvec = n_rvec; m_msg = n_msg; m_mvec = n_mvec; m_pend = n_pend;
    compare();
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d; tick(); req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    req = 1; we = 0; addr = a; tick(); req = 0;
  endtask

  task automatic event_on(logic [2:0] v);
    evt = 1; evt_vec = v; tick(); evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tot++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R14"; compare();
    tick();

    tag = "R3"; bus_wr(8'h00, 32'hFFFF_0001); bus_rd(8'h00);
    tag = "R1"; bus_wr(8'h04, 32'h0000_0003); tick();
    tag = "R2"; bus_rd(8'h04); tick(); bus_rd(8'h04);
    tag = "R1"; bus_wr(8'h04, 32'h10); bus_wr(8'h00, 32'h10); bus_wr(8'h04, 32'h0);
    tag = "R3"; bus_wr(8'h04, 32'hDEAD_BEEF); bus_rd(8'h04);
    tag = "R4"; bus_rd(8'h08); bus_rd(8'h0C); bus_rd(8'h20);
    bus_wr(8'h20, 32'h1234_5678); bus_wr(8'h08, 32'hFFFF_FFFF); bus_rd(8'h00); bus_rd(8'h08);
    tag = "R5"; bus_wr(8'h04, 32'h7); bus_wr(8'h01, 32'h0); bus_rd(8'h00);
    bus_rd(8'h05); bus_rd(8'h06); bus_rd(8'h04);

    tag = "R9";
    for (int i = 0; i < NP; i++) begin
      tbl_we = 1; tbl_idx = 3'(i); tbl_nvec = 8'(i); tick();
    end
    tbl_we = 0;
    npeers = 16'd5;
    tag = "R6"; bus_wr(8'h0C, {16'd3, 8'h00, 8'd2}); tick();
    bus_wr(8'h0C, {16'd4, 8'hEE, 8'd3}); bus_wr(8'h0C, {16'd1, 8'h00, 8'd0});
    tag = "R8"; bus_wr(8'h0C, {16'd3, 8'h00, 8'd3}); bus_wr(8'h0C, {16'd0, 8'h00, 8'd0});
    bus_wr(8'h0C, {16'd2, 8'h00, 8'd255});
    tag = "R7"; bus_wr(8'h0C, {16'd5, 8'h00, 8'd0}); bus_wr(8'h0C, {16'd4, 8'h00, 8'd0});
    npeers = 16'd20;
    bus_wr(8'h0C, {16'd9, 8'h00, 8'd0}); bus_wr(8'h0C, {16'd7, 8'h00, 8'd6});
    bus_wr(8'h0C, {16'hFFFF, 8'h00, 8'd0});
    tag = "R9"; tbl_we = 1; tbl_idx = 3'd2; tbl_nvec = 8'd0;
    bus_wr(8'h0C, {16'd2, 8'h00, 8'd1}); tbl_we = 0;
    bus_wr(8'h0C, {16'd2, 8'h00, 8'd0});

    tag = "R13"; bus_wr(8'h00, 32'hFFFF_FFFF); bus_wr(8'h04, 32'h0F0);
    event_on(3'd4); bus_rd(8'h04);
    req = 1; we = 1; addr = 8'h04; wdata = 32'hAA; evt = 1; evt_vec = 3'd0; tick();
    req = 0; we = 0; evt = 0; bus_rd(8'h04);
    req = 1; we = 0; addr = 8'h04; evt = 1; tick(); req = 0; evt = 0; tick();

    tag = "R10"; mmode = 1; tick();
    tag = "R13"; event_on(3'd3); bus_rd(8'h04);
    tag = "R10"; men = 1; event_on(3'd5); tick(); event_on(3'd0); event_on(3'd7);
    tag = "R11"; vmask = 8'b0100_0100; event_on(3'd2); event_on(3'd6); tick(); tick();
    tag = "R12"; vmask = 8'b0000_0100; tick(); tick();
    vmask = 8'b0000_0000; event_on(3'd1); tick(); tick();
    tag = "R11"; vmask = 8'hFF; event_on(3'd3); event_on(3'd1);
    men = 0; vmask = 8'h00; tick();
    tag = "R12"; men = 1; tick(); tick(); tick();

    tag = "R14"; vmask = 8'hFF; event_on(3'd5); bus_wr(8'h00, 32'h1); bus_wr(8'h04, 32'h1);
    mmode = 0; tick();
    #1 rst_n = 0; #1; model_reset(); compare();
    @(posedge clk); #1 rst_n = 1; compare(); tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule